// File: doc/BRIEF.md
# Scaled Integer Add/Subtract Unit

This block adds or subtracts two 64-bit integer operands and registers the result on the next clock edge. It can first multiply the first operand by four or by eight with a left shift. It works at two widths. In quadword mode the full 64-bit operands are used. In longword mode only the low halves are used, and the 32-bit sum is widened back to 64 bits by copying its sign bit into the upper half.

Signed overflow is detected at the width that was selected. It raises the trap flag only when the caller asks for the trapping variant of an unscaled operation. A scaled operation never raises the flag. The unit only flags the condition; acting on it is left to the surrounding pipeline.

Top module: `sadd_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` and `ovf_trap_o` are zero. Once reset is released, each output reflects the inputs sampled at the previous rising edge of `clk`.
- R2: In quadword mode (`size_long_i`=0), `result_o` is the shifted first operand plus `b_i` modulo 2^64 when `op_sub_i`=0. When `op_sub_i`=1 it is the shifted first operand minus `b_i`.
- R3: In longword mode (`size_long_i`=1), only bits 31:0 of `a_i` and `b_i` take part. Bits 63:32 of `result_o` are copies of bit 31 of the 32-bit result.
- R4: `scale_i` selects the shift applied to `a_i` before the operation: 2'b00 means no shift, 2'b01 means a left shift by 2, 2'b10 means a left shift by 3, and 2'b11 behaves as 2'b00. Bits shifted out beyond the selected width are lost.
- R5: For an unscaled operation with `trap_en_i`=1, `ovf_trap_o` is 1 exactly when signed overflow occurs. Overflow is judged at 32 bits in longword mode and at 64 bits in quadword mode.
- R6: When `trap_en_i`=0, `ovf_trap_o` stays 0 even if signed overflow occurs.
- R7: When `scale_i` is 2'b01 or 2'b10, `ovf_trap_o` stays 0 whatever `trap_en_i` is and whether or not the operation overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_i | input | 64 | First operand; this is the operand that gets scaled |
| b_i | input | 64 | Second operand |
| op_sub_i | input | 1 | 0 selects add, 1 selects first minus second |
| size_long_i | input | 1 | 1 selects longword (32-bit) mode, 0 selects quadword mode |
| scale_i | input | 2 | Shift applied to the first operand (see R4) |
| trap_en_i | input | 1 | Selects the overflow-trapping variant |
| result_o | output | 64 | Registered result |
| ovf_trap_o | output | 1 | Registered overflow-trap flag |

## Verification
Scaling and overflow detection meet in the same cycle when a shifted operand crosses the sign boundary, or when the sum that follows the shift overflows. Both cases are driven with the trapping variant selected, and the bench expects a correct wrapped result with the flag held low. Narrow-width overflow and wide-width no-overflow also meet in the same cycle: the same operand pair is sent once in longword mode and once in quadword mode. The bench expects the flag in the first case only, and a sign-extended result in the first case against the plain sum in the second.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    localparam int unsigned WORD_W_DEF = 64;
    localparam int unsigned HALF_W_DEF = 32;
    localparam int unsigned SHIFT_X4   = 2;
    localparam int unsigned SHIFT_X8   = 3;

    typedef enum logic [1:0] {
        SCL_NONE = 2'b00,
        SCL_X4   = 2'b01,
        SCL_X8   = 2'b10,
        SCL_RSVD = 2'b11
    } scale_e;

endpackage

// File: rtl/sadd_prescale.sv
module sadd_prescale
    import sadd_pkg::*;
#(
    parameter int unsigned W = WORD_W_DEF
) (
    input  scale_e         sel,
    input  logic [W-1:0]   opnd,
    output logic [W-1:0]   opnd_sh,
    output logic           scaled
);

    always_comb begin
        case (sel)
            SCL_X4: begin
                opnd_sh = opnd << SHIFT_X4;
                scaled  = 1'b1;
            end
            SCL_X8: begin
                opnd_sh = opnd << SHIFT_X8;
                scaled  = 1'b1;
            end
            default: begin
                opnd_sh = opnd;
                scaled  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sadd_addsub.sv
module sadd_addsub #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);

    logic [W-1:0] y_eff;
    logic [W-1:0] cin_vec;

    always_comb begin
        y_eff   = sub ? ~y : y;
        cin_vec = {{(W-1){1'b0}}, sub};
        sum     = x + y_eff + cin_vec;
        // signed overflow: same input signs, different result sign
        ovf     = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
    end

endmodule

// File: rtl/sadd_unit.sv
module sadd_unit
    import sadd_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned HALF_W = HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              op_sub_i,
    input  logic              size_long_i,
    input  logic [1:0]        scale_i,
    input  logic              trap_en_i,
    output logic [WORD_W-1:0] result_o,
    output logic              ovf_trap_o
);

    localparam int unsigned EXT_W = WORD_W - HALF_W;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic              trap;
    } st_t;

    st_t st_d, st_q;

    logic [WORD_W-1:0] a_sh;
    logic              scaled;
    logic [WORD_W-1:0] quad_sum;
    logic              quad_ovf;
    logic [HALF_W-1:0] long_sum;
    logic              long_ovf;
    logic              ovf_sel;

    sadd_prescale #(.W(WORD_W)) u_prescale (
        .sel     (scale_e'(scale_i)),
        .opnd    (a_i),
        .opnd_sh (a_sh),
        .scaled  (scaled)
    );

    sadd_addsub #(.W(WORD_W)) u_quad (
        .x   (a_sh),
        .y   (b_i),
        .sub (op_sub_i),
        .sum (quad_sum),
        .ovf (quad_ovf)
    );

    sadd_addsub #(.W(HALF_W)) u_long (
        .x   (a_sh[HALF_W-1:0]),
        .y   (b_i[HALF_W-1:0]),
        .sub (op_sub_i),
        .sum (long_sum),
        .ovf (long_ovf)
    );

    always_comb begin
        st_d = st_q;
        if (size_long_i) begin
            st_d.result = {{EXT_W{long_sum[HALF_W-1]}}, long_sum};
            ovf_sel     = long_ovf;
        end else begin
            st_d.result = quad_sum;
            ovf_sel     = quad_ovf;
        end
        st_d.trap = trap_en_i && !scaled && ovf_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o   = st_q.result;
    assign ovf_trap_o = st_q.trap;

    // R1: outputs are cleared when reset is released
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result_o == '0 && !ovf_trap_o));

    // R2: unscaled quadword add equals the plain modular sum
    p_quad_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(scale_i) == 2'b00 && !$past(op_sub_i) && !$past(size_long_i))
        |-> result_o == $past(a_i) + $past(b_i));

    // R3: longword results are sign-extended
    p_long_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size_long_i))
        |-> result_o[WORD_W-1:HALF_W] == {EXT_W{result_o[HALF_W-1]}});

    // R6: no trap without the enable
    p_trap_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(trap_en_i)) |-> !ovf_trap_o);

    // R7: scaled operations never trap
    p_scaled_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(scale_i) == 2'b01 || $past(scale_i) == 2'b10))
        |-> !ovf_trap_o);

endmodule

// File: tb/sadd_unit_tb.sv
module sadd_unit_tb;

    typedef struct {
        logic [63:0] res;
        logic        trap;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        op_sub_i = 1'b0;
    logic        size_long_i = 1'b0;
    logic [1:0]  scale_i = 2'b00;
    logic        trap_en_i = 1'b0;
    logic [63:0] result_o;
    logic        ovf_trap_o;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    sadd_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_i         (a_i),
        .b_i         (b_i),
        .op_sub_i    (op_sub_i),
        .size_long_i (size_long_i),
        .scale_i     (scale_i),
        .trap_en_i   (trap_en_i),
        .result_o    (result_o),
        .ovf_trap_o  (ovf_trap_o)
    );

    // Reference model written from the requirements (R2..R7)
    function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                   input logic sub, input logic lng,
                                   input logic [1:0] sc, input logic ten, input string tag);
        exp_t        e;
        int          sh;
        logic [63:0] as, r64;
        logic [31:0] r32, x, y;
        logic        ov;
        sh = (sc == 2'b01) ? 2 : (sc == 2'b10) ? 3 : 0;
        as = a << sh;
        if (lng) begin
            x   = as[31:0];
            y   = b[31:0];
            r32 = sub ? x - y : x + y;
            e.res = {{32{r32[31]}}, r32};
            ov  = sub ? (x[31] != y[31] && r32[31] != x[31])
                      : (x[31] == y[31] && r32[31] != x[31]);
        end else begin
            r64 = sub ? as - b : as + b;
            e.res = r64;
            ov  = sub ? (as[63] != b[63] && r64[63] != as[63])
                      : (as[63] == b[63] && r64[63] != as[63]);
        end
        e.trap = ten && (sh == 0) && ov;
        e.tag  = tag;
        return e;
    endfunction

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic sub,
                         input logic lng, input logic [1:0] sc, input logic ten,
                         input string tag);
        @(negedge clk);
        a_i = a; b_i = b; op_sub_i = sub; size_long_i = lng; scale_i = sc; trap_en_i = ten;
        sb.push_back(model(a, b, sub, lng, sc, ten, tag));
    endtask

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: one cycle after each drive, compare the registered outputs
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {result_o, ovf_trap_o}, {e.res, e.trap});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero during reset even with active inputs
        a_i = 64'h7fff_ffff_ffff_ffff; b_i = 64'h1; trap_en_i = 1'b1;
        repeat (4) @(posedge clk);
        #1 check("R1 reset", {result_o, ovf_trap_o}, 65'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: quadword add/sub
        drive(64'd5, 64'd7, 1'b0, 1'b0, 2'b00, 1'b0, "R2 add");
        drive(64'd5, 64'd7, 1'b1, 1'b0, 2'b00, 1'b1, "R2 sub");
        drive(64'hffff_ffff_ffff_ffff, 64'd1, 1'b0, 1'b0, 2'b00, 1'b1, "R2 wrap");
        // R5: quadword overflow traps
        drive(64'h7fff_ffff_ffff_ffff, 64'd1, 1'b0, 1'b0, 2'b00, 1'b1, "R5 quad add ovf");
        drive(64'h8000_0000_0000_0000, 64'd1, 1'b1, 1'b0, 2'b00, 1'b1, "R5 quad sub ovf");
        // R6: same overflow without enable
        drive(64'h7fff_ffff_ffff_ffff, 64'd1, 1'b0, 1'b0, 2'b00, 1'b0, "R6 no enable");
        // R3 + R5: longword overflow at 32 bits, same data no 64-bit overflow
        drive(64'hdead_beef_0000_0001, 64'h1234_5678_7fff_ffff, 1'b0, 1'b1, 2'b00, 1'b1, "R3 long sext ovf");
        drive(64'hdead_beef_0000_0001, 64'h1234_5678_7fff_ffff, 1'b0, 1'b0, 2'b00, 1'b1, "R5 quad same data");
        drive(64'hffff_ffff_0000_0003, 64'h0000_0001_0000_0005, 1'b1, 1'b1, 2'b00, 1'b0, "R3 long sub");
        // R4: scale encodings
        drive(64'd3, 64'd1, 1'b0, 1'b0, 2'b01, 1'b0, "R4 x4 add");
        drive(64'd3, 64'd1, 1'b1, 1'b0, 2'b10, 1'b0, "R4 x8 sub");
        drive(64'd3, 64'd1, 1'b0, 1'b0, 2'b11, 1'b0, "R4 reserved");
        drive(64'h0000_0000_4000_0001, 64'd0, 1'b0, 1'b1, 2'b01, 1'b0, "R4 long shift loss");
        drive(64'h0000_0000_7fff_ffff, 64'd1, 1'b0, 1'b1, 2'b11, 1'b1, "R4 reserved traps");
        // R7: scaled with overflow and enable
        drive(64'h2000_0000_0000_0000, 64'd0, 1'b0, 1'b0, 2'b01, 1'b1, "R7 shift into sign");
        drive(64'h1000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 2'b10, 1'b1, "R7 scaled add ovf");
        drive(64'h0000_0000_1000_0000, 64'h0000_0000_7000_0000, 1'b0, 1'b1, 2'b01, 1'b1, "R7 long scaled ovf");
        // drain
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule